// File: doc/BRIEF.md
# Table-Driven Waveform Sequencer with Per-Step Hold

The block plays back a fixed digital waveform, one step at a time, in an endless loop. For each step there are two constant table entries, both picked by the same step index. The first is the output word for that step. The second is the number of clock cycles the step lasts. A down-counting delay counter measures how long the current step has lasted. When the count runs out, selection logic moves the step index to the next entry. After the final entry the index wraps to entry 0. The output word is registered, so it changes only on the clock edge where the step index changes.

The tables are computed from the step index at elaboration time. The pattern table is (29 × step + 7) modulo 2^DataW. The duration table is 3 for step 0, 1 for step 1, 0 for step 2 and 80 for step 3. Every step from 4 upward has a duration of (step mod 4) + 1. A duration of 0 is played as 1, so the sequence can never stall. By default there are 16 steps, the output is 8 bits wide and the duration field is 8 bits wide. One full pass of the default sequence takes 115 cycles.

Top module: `wave_seq`

## Requirements
- R1: While the synchronous reset is high, wave equals the pattern of step 0. After the last clock edge with reset high, step 0 stays on wave for its table duration, which is 3 cycles. A reset asserted in the middle of the sequence has the same effect.
- R2: Step i drives wave = (29*i + 7) mod 2^DataW. With the defaults the steps show, in order, 7, 36, 65, 94, 123, 152, 181, 210, 239, 12, 41, 70, 99, 128, 157, 186.
- R3: Step i lasts its table duration. The table gives 3, 1, 0 and 80 for steps 0 to 3, and (i mod 4)+1 for every step i ≥ 4.
- R4: A step whose duration entry is 1 is on wave for exactly one clock cycle.
- R5: A step whose duration entry is 80 is on wave for exactly 80 consecutive cycles. This holds even though that step sits in the middle of the sequence.
- R6: A step whose duration entry is 0 is on wave for exactly one clock cycle.
- R7: After the last step the sequence returns to step 0 with no gap and no extra cycle, and then repeats identically.
- R8: wave changes only on the clock edge where the step index advances, and it stays stable for the whole of a step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wave | output | DataW | Registered waveform word of the current step |

## Verification
The assertions check the per-cycle rules on every clock.
- While no advance strobe occurs, the step index and the wave output stay unchanged and the delay counter decrements by one.
- An advance moves the index up by one, or from the last step back to 0.

Only the bench scenarios can show the following.
- The actual output values and each step's exact run length, including the 0, 1 and 80 entries.
- The seamless wrap over two full passes.
- The restart of step 0 after a reset asserted mid-sequence.

// File: rtl/wave_seq_pkg.sv
package wave_seq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;  // current step ends on this edge
    logic wrap;     // the step that ends is the last one
  } seq_ctrl_t;

endpackage

// File: rtl/wave_seq_ctrl.sv
module wave_seq_ctrl
  import wave_seq_pkg::*;
#(
  parameter int DurW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            atLast,
  input  logic [DurW-1:0] durFirst,
  input  logic [DurW-1:0] durNext,
  output seq_ctrl_t       seqCtrl,
  output logic [DurW-1:0] delayCnt
);

  // Cycles still to spend after this one; a zero entry acts as one cycle.
  function automatic logic [DurW-1:0] holdLoad(input logic [DurW-1:0] d);
    return (d == '0) ? '0 : d - DurW'(1);
  endfunction

  always_comb begin
    seqCtrl.advance = (delayCnt == '0);
    seqCtrl.wrap    = seqCtrl.advance & atLast;
  end

  always_ff @(posedge clk) begin
    if (rst)                  delayCnt <= holdLoad(durFirst);
    else if (seqCtrl.advance) delayCnt <= holdLoad(durNext);
    else                      delayCnt <= delayCnt - DurW'(1);
  end

endmodule

// File: rtl/wave_seq_dp.sv
module wave_seq_dp
  import wave_seq_pkg::*;
#(
  parameter int NumSteps = 16,
  parameter int DataW    = 8,
  parameter int DurW     = 8,
  localparam int StepW   = (NumSteps > 1) ? $clog2(NumSteps) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_ctrl_t        seqCtrl,
  output logic [DataW-1:0] wave,
  output logic [StepW-1:0] stepIdx,
  output logic             atLast,
  output logic [DurW-1:0]  durFirst,
  output logic [DurW-1:0]  durNext
);

  logic [DataW-1:0] patTab [NumSteps];
  logic [DurW-1:0]  durTab [NumSteps];
  logic [StepW-1:0] followIdx;
  logic [StepW-1:0] nextIdx;

  // Constant tables, computed per entry
  for (genvar i = 0; i < NumSteps; i++) begin : g_tab
    localparam int PatVal = (29 * i + 7) % (1 << DataW);
    localparam int DurVal = (i == 0) ? 3 :
                            (i == 1) ? 1 :
                            (i == 2) ? 0 :
                            (i == 3) ? 80 : (i % 4) + 1;
    assign patTab[i] = DataW'(PatVal);
    assign durTab[i] = DurW'(DurVal);
  end

  assign atLast    = (stepIdx == StepW'(NumSteps - 1));
  assign followIdx = seqCtrl.wrap ? '0 : stepIdx + StepW'(1);

  // Selection of the next step index
  always_comb begin
    unique case ({seqCtrl.advance, seqCtrl.wrap})
      2'b10:   nextIdx = stepIdx + StepW'(1);
      2'b11:   nextIdx = '0;
      default: nextIdx = stepIdx;
    endcase
  end

  assign durFirst = durTab[0];
  assign durNext  = durTab[followIdx];

  always_ff @(posedge clk) begin
    if (rst) begin
      stepIdx <= '0;
      wave    <= patTab[0];
    end else begin
      stepIdx <= nextIdx;
      if (seqCtrl.advance) wave <= patTab[nextIdx];
    end
  end

endmodule

// File: rtl/wave_seq.sv
module wave_seq
  import wave_seq_pkg::*;
#(
  parameter int NumSteps = 16,
  parameter int DataW    = 8,
  parameter int DurW     = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [DataW-1:0] wave
);

  localparam int StepW = (NumSteps > 1) ? $clog2(NumSteps) : 1;

  seq_ctrl_t        seqCtrl;
  logic [StepW-1:0] stepIdx;
  logic [DurW-1:0]  delayCnt;
  logic [DurW-1:0]  durFirst;
  logic [DurW-1:0]  durNext;
  logic             atLast;

  wave_seq_ctrl #(.DurW(DurW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .atLast   (atLast),
    .durFirst (durFirst),
    .durNext  (durNext),
    .seqCtrl  (seqCtrl),
    .delayCnt (delayCnt)
  );

  wave_seq_dp #(.NumSteps(NumSteps), .DataW(DataW), .DurW(DurW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .seqCtrl  (seqCtrl),
    .wave     (wave),
    .stepIdx  (stepIdx),
    .atLast   (atLast),
    .durFirst (durFirst),
    .durNext  (durNext)
  );

endmodule

// File: rtl/wave_seq_chk.sv
module wave_seq_chk #(
  parameter int NumSteps = 16,
  parameter int DataW    = 8,
  parameter int DurW     = 8,
  parameter int StepW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [DataW-1:0] wave,
  input logic [StepW-1:0] stepIdx,
  input logic [DurW-1:0]  delayCnt,
  input logic             advance
);

  // R8
  wave_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(wave));

  // R3
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(stepIdx));

  // R3
  delay_count_chk: assert property (@(posedge clk) disable iff (rst)
    !advance |=> (delayCnt == $past(delayCnt) - DurW'(1)));

  // R7
  step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && stepIdx == StepW'(NumSteps - 1)) |=> (stepIdx == '0));

  // R2
  step_incr_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && stepIdx != StepW'(NumSteps - 1)) |=>
      (stepIdx == $past(stepIdx) + StepW'(1)));

endmodule

bind wave_seq wave_seq_chk #(
  .NumSteps (NumSteps),
  .DataW    (DataW),
  .DurW     (DurW),
  .StepW    (StepW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wave     (wave),
  .stepIdx  (stepIdx),
  .delayCnt (delayCnt),
  .advance  (seqCtrl.advance)
);

// File: tb/wave_seq_tb.sv
module wave_seq_tb;

  localparam int NSteps = 16;

  // {expected pattern, cycles on wave} per step, from R2, R3, R4, R5, R6
  localparam logic [15:0] ExpTab [NSteps] = '{
    {8'd7,   8'd3},  {8'd36,  8'd1},  {8'd65,  8'd1},  {8'd94,  8'd80},
    {8'd123, 8'd1},  {8'd152, 8'd2},  {8'd181, 8'd3},  {8'd210, 8'd4},
    {8'd239, 8'd1},  {8'd12,  8'd2},  {8'd41,  8'd3},  {8'd70,  8'd4},
    {8'd99,  8'd1},  {8'd128, 8'd2},  {8'd157, 8'd3},  {8'd186, 8'd4}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] wave;

  int checks = 0;
  int errors = 0;

  wave_seq u_dut (.clk(clk), .rst(rst), .wave(wave));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: wave actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Walk one step, sampling every cycle it should be on wave
  task automatic walk_step(input string req, input int s);
    logic [7:0] exp = ExpTab[s][15:8];
    int         n   = int'(ExpTab[s][7:0]);
    logic [7:0] bad = exp;
    bit         ok  = 1'b1;
    for (int k = 0; k < n; k++) begin
      if (wave !== exp && ok) begin ok = 1'b0; bad = wave; end
      @(negedge clk);
    end
    check(req, bad, exp);
  endtask

  function automatic string req_of(input int s, input int rep);
    if (s == 0 && rep > 0) return "R7";
    if (s == 0) return "R1";
    if (s == 3) return "R5";
    if (s == 2) return "R6";
    if (s == 1 || s == 4 || s == 8 || s == 12) return "R4";
    return (s % 2) ? "R2" : "R3";
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R1", wave, 8'd7);          // reset state
    rst = 1'b0;
    // Two full passes plus the start of a third, seamless (R7, R8)
    for (int rep = 0; rep < 2; rep++)
      for (int s = 0; s < NSteps; s++)
        walk_step(req_of(s, rep), s);
    check("R7", wave, 8'd7);          // third pass starts at step 0
    // Run into the long step, then reset in its middle (R1)
    repeat (3 + 1 + 1 + 40) @(negedge clk);
    check("R5", wave, 8'd94);
    rst = 1'b1;
    @(negedge clk);
    check("R1", wave, 8'd7);
    rst = 1'b0;
    walk_step("R1", 0);
    walk_step("R4", 1);
    walk_step("R6", 2);
    check("R5", wave, 8'd94);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule